// File: doc/BRIEF.md
# Scalar-Only Instruction Detector

This block sits at the front of the issue stage. It holds one flag bit for each architectural register. A set flag means that the register is currently mapped as a vector. For each instruction it receives, the block reads three flags in parallel: the first source, the second source and the destination. The result goes out one cycle later on one of two routes. Instructions that touch only scalar registers go straight to the scalar ALU or instruction queue. All other instructions go to the vector issue path.

The flags are never written by instructions. They are derived from the vector-mapping control entries. Each mapping entry that is written either marks its register as vectorised (entry enabled) or marks it scalar again (entry disabled). These updates reach the flag table through a single write port. When several entries are written in the same cycle, an arbiter applies them one per cycle, lowest entry first. Entries that lose the arbitration wait in a pending slot.

Top module: `scalar_issue_filter`

## Requirements
- R1: Reset clears every flag and both route outputs. After reset, a lookup of any register returns the scalar route.
- R2: With the floating-point file present (HAS_FP=1, the default) the table has 64 flags. Integer register n uses index n and floating-point register n uses index 32+n. Setting one of these flags does not affect the other.
- R3: A lookup reads the first-source, second-source and destination flags in the same cycle. If any flag that is taken into account is set, the instruction takes the vector route.
- R4: When the lookup marks the second source as unused (src2_used=0), the second-source flag is ignored.
- R5: One cycle after a valid lookup, exactly one of alu_valid (fully scalar) or vec_valid (any vectorised operand) is high, and out_tag carries the tag of that lookup.
- R6: A mapping write with the enable bit at 1 sets the flag of the named register. A mapping write with the enable bit at 0 clears it.
- R7: A mapping write that wins arbitration changes the flag at the next clock edge. A lookup in the same cycle as the write sees the old flag value. A lookup in the next cycle sees the new value.
- R8: Mapping writes that arrive together are applied one per cycle in ascending entry order. When two of them name the same register, the flag ends with the value from the highest-numbered entry.
- R9: The flag table changes at most one flag per cycle.
- R10: A cycle with no valid lookup produces no route output in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_src1 | input | IDX_W | First source register index |
| lk_src2 | input | IDX_W | Second source register index |
| lk_dst | input | IDX_W | Destination register index |
| lk_src2_used | input | 1 | The second source is a real register operand |
| lk_tag | input | TAG_W | Instruction tag carried to the output |
| map_we | input | NUM_MAP | Per-entry mapping write strobe |
| map_reg | input | NUM_MAP*IDX_W | Register index for each entry, entry i at bits i*IDX_W upward |
| map_en | input | NUM_MAP | Per-entry enable: 1 marks the register vectorised, 0 marks it scalar |
| alu_valid | output | 1 | The previous lookup was fully scalar |
| vec_valid | output | 1 | The previous lookup has a vectorised operand |
| out_tag | output | TAG_W | Tag of the routed instruction |

## Verification
A flag update and a lookup of the same register can occur in the same cycle. The bench provokes this by driving a mapping write and a lookup of that register on the same edge. It expects the route that the old flag gives, and then expects the new route on the lookup in the next cycle. The bench also issues several mapping writes together and looks up the affected registers in the cycles that follow. From this it judges the serialisation order, and also the last-writer result when two entries name the same register.

// File: rtl/sif_pkg.sv
package sif_pkg;

    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_ALU  = 2'd1,
        ROUTE_VEC  = 2'd2
    } route_e;

    localparam int unsigned INT_REGS = 32;
    localparam int unsigned RD_PORTS = 3;
    localparam int unsigned RD_SRC1  = 0;
    localparam int unsigned RD_SRC2  = 1;
    localparam int unsigned RD_DST   = 2;

endpackage

// File: rtl/sif_flag_table.sv
module sif_flag_table #(
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned IDX_W    = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic                              wr_val,
    input  logic [sif_pkg::RD_PORTS*IDX_W-1:0] rd_idx,
    output logic [sif_pkg::RD_PORTS-1:0]       rd_flag,
    output logic [NUM_REGS-1:0]               flags_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0] flags;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    // single write port
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.flags[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // three independent read ports
    for (genvar g = 0; g < sif_pkg::RD_PORTS; g++) begin : g_rd
        assign rd_flag[g] = st_q.flags[rd_idx[g*IDX_W +: IDX_W]];
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/sif_update_arb.sv
module sif_update_arb #(
    parameter int unsigned NUM_MAP = 4,
    parameter int unsigned IDX_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_MAP-1:0]         map_we,
    input  logic [NUM_MAP*IDX_W-1:0]   map_reg,
    input  logic [NUM_MAP-1:0]         map_en,
    output logic                       wr_en,
    output logic [IDX_W-1:0]           wr_idx,
    output logic                       wr_val
);

    typedef struct packed {
        logic [NUM_MAP-1:0]       pend_v;
        logic [NUM_MAP*IDX_W-1:0] pend_reg;
        logic [NUM_MAP-1:0]       pend_en;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_MAP-1:0]       eff_v;
    logic [NUM_MAP*IDX_W-1:0] eff_reg;
    logic [NUM_MAP-1:0]       eff_en;

    // a fresh write replaces whatever the entry still had pending
    for (genvar g = 0; g < NUM_MAP; g++) begin : g_eff
        assign eff_v[g]                  = map_we[g] | st_q.pend_v[g];
        assign eff_reg[g*IDX_W +: IDX_W] = map_we[g] ? map_reg[g*IDX_W +: IDX_W]
                                                     : st_q.pend_reg[g*IDX_W +: IDX_W];
        assign eff_en[g]                 = map_we[g] ? map_en[g] : st_q.pend_en[g];
    end

    // lowest requesting entry owns the write port this cycle
    always_comb begin
        logic granted;
        st_d    = st_q;
        granted = 1'b0;
        wr_en   = 1'b0;
        wr_idx  = '0;
        wr_val  = 1'b0;
        for (int i = 0; i < int'(NUM_MAP); i++) begin
            st_d.pend_reg[i*IDX_W +: IDX_W] = eff_reg[i*IDX_W +: IDX_W];
            st_d.pend_en[i]                 = eff_en[i];
            if (eff_v[i] && !granted) begin
                granted         = 1'b1;
                wr_en           = 1'b1;
                wr_idx          = eff_reg[i*IDX_W +: IDX_W];
                wr_val          = eff_en[i];
                st_d.pend_v[i]  = 1'b0;
            end else begin
                st_d.pend_v[i]  = eff_v[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sif_scalar_check.sv
module sif_scalar_check (
    input  logic [sif_pkg::RD_PORTS-1:0] flag_in,
    input  logic                         src2_used,
    output logic                         is_scalar
);

    logic [sif_pkg::RD_PORTS-1:0] live;

    always_comb begin
        live                   = flag_in;
        live[sif_pkg::RD_SRC2] = flag_in[sif_pkg::RD_SRC2] & src2_used;
        is_scalar              = ~(|live);
    end

endmodule

// File: rtl/scalar_issue_filter.sv
module scalar_issue_filter #(
    parameter  int unsigned HAS_FP   = 1,
    parameter  int unsigned NUM_MAP  = 4,
    parameter  int unsigned TAG_W    = 8,
    localparam int unsigned NUM_REGS = sif_pkg::INT_REGS * ((HAS_FP != 0) ? 2 : 1),
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [IDX_W-1:0]         lk_src1,
    input  logic [IDX_W-1:0]         lk_src2,
    input  logic [IDX_W-1:0]         lk_dst,
    input  logic                     lk_src2_used,
    input  logic [TAG_W-1:0]         lk_tag,
    input  logic [NUM_MAP-1:0]       map_we,
    input  logic [NUM_MAP*IDX_W-1:0] map_reg,
    input  logic [NUM_MAP-1:0]       map_en,
    output logic                     alu_valid,
    output logic                     vec_valid,
    output logic [TAG_W-1:0]         out_tag
);

    import sif_pkg::*;

    typedef struct packed {
        route_e           route;
        logic [TAG_W-1:0] tag;
    } out_state_t;

    out_state_t out_d, out_q;

    logic                         wr_en;
    logic [IDX_W-1:0]             wr_idx;
    logic                         wr_val;
    logic [RD_PORTS*IDX_W-1:0]    rd_idx;
    logic [RD_PORTS-1:0]          rd_flag;
    logic [NUM_REGS-1:0]          flag_vec;
    logic                         is_scalar;

    always_comb begin
        rd_idx                            = '0;
        rd_idx[RD_SRC1*IDX_W +: IDX_W]    = lk_src1;
        rd_idx[RD_SRC2*IDX_W +: IDX_W]    = lk_src2;
        rd_idx[RD_DST*IDX_W +: IDX_W]     = lk_dst;
    end

    sif_update_arb #(
        .NUM_MAP (NUM_MAP),
        .IDX_W   (IDX_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_we  (map_we),
        .map_reg (map_reg),
        .map_en  (map_en),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val)
    );

    sif_flag_table #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .rd_idx  (rd_idx),
        .rd_flag (rd_flag),
        .flags_o (flag_vec)
    );

    sif_scalar_check u_check (
        .flag_in   (rd_flag),
        .src2_used (lk_src2_used),
        .is_scalar (is_scalar)
    );

    always_comb begin
        out_d = out_q;
        if (!lk_valid) begin
            out_d.route = ROUTE_IDLE;
        end else begin
            out_d.route = is_scalar ? ROUTE_ALU : ROUTE_VEC;
            out_d.tag   = lk_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{route: ROUTE_IDLE, tag: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign alu_valid = (out_q.route == ROUTE_ALU);
    assign vec_valid = (out_q.route == ROUTE_VEC);
    assign out_tag   = out_q.tag;

endmodule

// File: rtl/sif_checker.sv
module sif_checker #(
    parameter int unsigned IDX_W    = 6,
    parameter int unsigned NUM_REGS = 64,
    parameter int unsigned TAG_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_valid,
    input logic [IDX_W-1:0]    lk_src1,
    input logic [IDX_W-1:0]    lk_dst,
    input logic                lk_src2_used,
    input logic [TAG_W-1:0]    lk_tag,
    input logic                alu_valid,
    input logic                vec_valid,
    input logic [TAG_W-1:0]    out_tag,
    input logic [NUM_REGS-1:0] flags
);

    p_one_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_valid && vec_valid));

    p_tag_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (out_tag == $past(lk_tag)) && (alu_valid || vec_valid));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !alu_valid && !vec_valid);

    p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags ^ $past(flags)) <= 1);

    p_vec_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && (flags[lk_src1] || flags[lk_dst]) |=> vec_valid);

    p_src2_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && !lk_src2_used && !flags[lk_src1] && !flags[lk_dst] |=> alu_valid);

endmodule

bind scalar_issue_filter sif_checker #(
    .IDX_W    (IDX_W),
    .NUM_REGS (NUM_REGS),
    .TAG_W    (TAG_W)
) u_sif_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_src1      (lk_src1),
    .lk_dst       (lk_dst),
    .lk_src2_used (lk_src2_used),
    .lk_tag       (lk_tag),
    .alu_valid    (alu_valid),
    .vec_valid    (vec_valid),
    .out_tag      (out_tag),
    .flags        (flag_vec)
);

// File: tb/scalar_issue_filter_bench.sv
module scalar_issue_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NMAP  = 4;
    localparam int IW    = 6;
    localparam int TW    = 8;
    localparam int NREGS = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            lk_valid;
    logic [IW-1:0]   lk_src1, lk_src2, lk_dst;
    logic            lk_src2_used;
    logic [TW-1:0]   lk_tag;
    logic [NMAP-1:0] map_we;
    logic [NMAP*IW-1:0] map_reg;
    logic [NMAP-1:0] map_en;
    logic            alu_valid, vec_valid;
    logic [TW-1:0]   out_tag;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [NREGS-1:0] ref_flags = '0;
    logic [TW-1:0] tag_ctr = '0;

    typedef struct {
        logic [TW-1:0] tag;
        bit            scalar;
        string         req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scalar_issue_filter #(.HAS_FP(1), .NUM_MAP(NMAP), .TAG_W(TW)) u_scalar_issue_filter (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_src1(lk_src1),
        .lk_src2(lk_src2), .lk_dst(lk_dst), .lk_src2_used(lk_src2_used),
        .lk_tag(lk_tag), .map_we(map_we), .map_reg(map_reg), .map_en(map_en),
        .alu_valid(alu_valid), .vec_valid(vec_valid), .out_tag(out_tag)
    );

    task automatic set_map(input int ent, input int regi, input bit en);
        map_we[ent]            = 1'b1;
        map_reg[ent*IW +: IW]  = IW'(regi);
        map_en[ent]            = en;
    endtask

    // drives one cycle; expectation comes from the bench flag model
    task automatic step(input bit v, input int s1, input int s2, input int d,
                        input bit used, input string req);
        exp_t e;
        lk_valid     = v;
        lk_src1      = IW'(s1);
        lk_src2      = IW'(s2);
        lk_dst       = IW'(d);
        lk_src2_used = used;
        lk_tag       = tag_ctr;
        if (v) begin
            e.tag    = tag_ctr;
            e.scalar = !ref_flags[s1] && !ref_flags[d] && !(used && ref_flags[s2]);
            e.req    = req;
            exp_q.push_back(e);
            tag_ctr  = tag_ctr + 1'b1;
        end
        @(negedge clk);
        lk_valid = 1'b0;
        map_we   = '0;
    endtask

    // monitor: pops one expectation per routed result
    always @(negedge clk) begin
        if (rst_n && !finished && (alu_valid || vec_valid)) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected route alu=%0b vec=%0b expected none", alu_valid, vec_valid);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (alu_valid !== e.scalar || vec_valid !== !e.scalar || out_tag !== e.tag) begin
                    bad++;
                    $display("FAIL %s alu=%0b vec=%0b tag=%0d expected alu=%0b vec=%0b tag=%0d",
                             e.req, alu_valid, vec_valid, out_tag, e.scalar, !e.scalar, e.tag);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_src1 = '0; lk_src2 = '0; lk_dst = '0;
        lk_src2_used = 1'b0; lk_tag = '0; map_we = '0; map_reg = '0; map_en = '0;
        repeat (3) @(negedge clk);
        total++;
        if (alu_valid !== 1'b0 || vec_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset outputs alu=%0b vec=%0b expected 0 0", alu_valid, vec_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads scalar after reset
        for (int r = 0; r < NREGS; r++) step(1'b1, r, r, r, 1'b1, "R1");

        // R6: set integer reg 5
        set_map(1, 5, 1'b1); step(1'b0, 0, 0, 0, 1'b0, "R6");
        ref_flags[5] = 1'b1;
        step(1'b1, 5, 0, 1, 1'b1, "R6");
        step(1'b1, 1, 2, 5, 1'b1, "R3");
        step(1'b1, 1, 5, 2, 1'b1, "R3");
        step(1'b1, 1, 5, 2, 1'b0, "R4");
        step(1'b1, 3, 4, 6, 1'b1, "R3");

        // R2: fp reg 5 (index 37) independent of integer reg 5
        step(1'b1, 37, 0, 37, 1'b1, "R2");
        set_map(0, 37, 1'b1); step(1'b0, 0, 0, 0, 1'b0, "R2");
        ref_flags[37] = 1'b1;
        step(1'b1, 0, 37, 0, 1'b1, "R2");
        step(1'b1, 36, 0, 38, 1'b1, "R2");
        step(1'b1, 63, 63, 63, 1'b1, "R2");

        // R7: write and lookup of the same register in one cycle
        set_map(2, 40, 1'b1); step(1'b1, 0, 0, 40, 1'b1, "R7");
        ref_flags[40] = 1'b1;
        step(1'b1, 0, 0, 40, 1'b1, "R7");

        // R6/R7: disable clears, same-cycle lookup sees old
        set_map(3, 5, 1'b0); step(1'b1, 5, 0, 0, 1'b0, "R7");
        ref_flags[5] = 1'b0;
        step(1'b1, 5, 0, 0, 1'b0, "R6");

        // R10: idle cycle, then check quiet outputs
        step(1'b0, 0, 0, 0, 1'b0, "R10");
        total++;
        if (alu_valid !== 1'b0 || vec_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10 idle outputs alu=%0b vec=%0b expected 0 0", alu_valid, vec_valid);
        end

        // R8: entries 0 and 2 together, applied one per cycle
        set_map(0, 10, 1'b1); set_map(2, 11, 1'b1);
        step(1'b1, 10, 0, 11, 1'b1, "R8");
        ref_flags[10] = 1'b1;
        step(1'b1, 11, 0, 0, 1'b1, "R8");
        ref_flags[11] = 1'b1;
        step(1'b1, 11, 0, 0, 1'b1, "R8");
        step(1'b1, 0, 10, 0, 1'b1, "R8");

        // R8: same register from entries 1 (set) and 3 (clear)
        set_map(1, 20, 1'b1); set_map(3, 20, 1'b0);
        step(1'b1, 20, 0, 0, 1'b1, "R8");
        ref_flags[20] = 1'b1;
        step(1'b1, 20, 0, 0, 1'b1, "R8");
        ref_flags[20] = 1'b0;
        step(1'b1, 20, 0, 0, 1'b1, "R8");
        step(1'b1, 0, 0, 20, 1'b1, "R8");

        // back-to-back mixed lookups
        step(1'b1, 10, 11, 40, 1'b1, "R5");
        step(1'b1, 1, 2, 3, 1'b1, "R5");
        step(1'b1, 37, 1, 2, 1'b0, "R5");

        repeat (3) step(1'b0, 0, 0, 0, 1'b0, "R10");
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R5 missing routes: %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule